// File: doc/BRIEF.md
# FIFO Threshold and Interrupt Pacing Block

This block sits between the serial bit engine of a two-wire bus controller and the CPU. It owns a transmit FIFO that the CPU fills and the bit engine drains, and a receive FIFO that the bit engine fills and the CPU drains. A per-direction threshold, together with a down-counter of the bytes still to move in the current transfer, decides when the CPU is asked to service a FIFO.

Four events are produced. The ready events fire when a full threshold's worth of work can be done. The draining events fire when the bytes left in the transfer can no longer make up a full threshold, so the CPU moves the short remainder. Each event latches into a status bit that software clears by writing a one. The interrupt output is the OR of the status bits whose enables are set. Enables have separate set and clear registers.

Software programs the thresholds, loads the byte count and enables the events it wants. After that it only reacts to the interrupt: it reads the masked status, moves data through the data register and clears the bits it has handled.

Top module: `fifo_pace_irq`

## Requirements
- R1: After a synchronous active-low reset, both FIFOs are empty, the remaining count is 0, all status and enable bits are 0, both threshold fields are 0 and `irq` is low.
- R2: Register 0 (config) holds the TX threshold minus one in bits [5:0] and the RX threshold minus one in bits [13:8]. Both fields read back, every other bit reads 0, and a field value of 0 means a threshold of 1.
- R3: Status bit 0 (RX ready) is set when the RX FIFO level is at or above the RX threshold.
- R4: Status bit 1 (RX draining) is set when the remaining count is 0 and the RX FIFO level is between 1 and the RX threshold minus one.
- R5: Let the unwritten bytes be the remaining count minus the TX FIFO level, with a floor of 0. Status bit 2 (TX ready) is set when the TX level is below the TX threshold and the unwritten bytes are at least the TX threshold.
- R6: Status bit 3 (TX draining) is set when the TX level is below the TX threshold and the unwritten bytes are between 1 and the TX threshold minus one.
- R7: Writing to register 2 clears each status bit whose data bit is 1 for that cycle. A bit whose condition still holds is set again one cycle later. Zero data bits leave their status bits unchanged, and a status bit stays set after its condition goes away.
- R8: A write to register 4 sets the enable bits given by the ones in the data, and a write to register 5 clears them. Both registers read back the enables. Register 2 reads status AND enable, register 3 reads the raw status, and `irq` is high exactly when some status bit and its enable are both 1.
- R9: Writing config with bit 6 set empties the TX FIFO, and writing it with bit 14 set empties the RX FIFO. Both bits read back as 0.
- R10: Register 7 bits [2:0] report the depth code, and the FIFO depth is 8 shifted left by that code. Each FIFO holds exactly that many bytes. A push into a full FIFO is ignored, and so is a pop from an empty one.
- R11: A write to register 1 with a nonzero value loads the remaining count, and a write of 0 is ignored. The count drops by one for each byte the bit engine moves (an accepted RX push or an accepted TX pop) and stops at 0. Reading register 1 returns the count.
- R12: A write to register 6 pushes its low byte into the TX FIFO, and the bit engine sees the bytes in write order on `eng_tx_data`. A read of register 6 returns the oldest RX byte and pops it, or returns 0 when the RX FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX when the address is 6) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| eng_rx_push | input | 1 | Bit engine delivers a received byte |
| eng_rx_data | input | DW | Received byte |
| eng_rx_room | output | 1 | RX FIFO is not full |
| eng_tx_pop | input | 1 | Bit engine takes the next byte to send |
| eng_tx_data | output | DW | Oldest TX byte |
| eng_tx_avail | output | 1 | TX FIFO is not empty |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach from the ports are the draining conditions. They need the remaining count, the FIFO level and the threshold placed relative to each other, which means a count load, engine traffic and CPU traffic in the right proportions. A second hard case is a status bit that stays set after its condition has gone away, where a zero write must be seen to leave it alone. Directed sequences place each draining event just below its threshold and build the stale sticky bit on purpose. A seeded random walk then mixes count loads, threshold changes, FIFO clears and both kinds of data movement. After every step it clears all status and reads the raw status back one cycle later, so it sees exactly the conditions that currently hold.

// File: rtl/pace_pkg.sv
// Shared register indices, status bit positions and field layout for the
// FIFO pacing block. Assumes a 16-bit register port.
package pace_pkg;
    localparam int RW     = 16;  // register width
    localparam int THR_W  = 6;   // threshold field width
    localparam int NEV    = 4;   // number of status events
    localparam int TX_THR_LSB = 0;
    localparam int RX_THR_LSB = 8;
    localparam int CFG_TXCLR  = 6;
    localparam int CFG_RXCLR  = 14;

    localparam int EV_RX_RDY = 0;
    localparam int EV_RX_DRN = 1;
    localparam int EV_TX_RDY = 2;
    localparam int EV_TX_DRN = 3;

    typedef enum logic [2:0] {
        A_CFG   = 3'd0,
        A_COUNT = 3'd1,
        A_STAT  = 3'd2,
        A_RAW   = 3'd3,
        A_ENSET = 3'd4,
        A_ENCLR = 3'd5,
        A_DATA  = 3'd6,
        A_INFO  = 3'd7
    } pace_addr_e;
endpackage

// File: rtl/pace_fifo.sv
// Synchronous FIFO with a level counter and a one-cycle clear.
// Assumes DEPTH is a power of two. A push when full and a pop when empty
// are dropped. A clear wins over a push or pop in the same cycle.
module pace_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    // Storage write: only accepted pushes land in the array.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= push_data;
    end

    // Pointer and level upkeep, clear returns to the empty state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    assert_full_push_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full && (level == LW'(DEPTH)));
    assert_empty_pop_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> empty);
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (level == '0));
endmodule

// File: rtl/pace_events.sv
// Combinational event conditions from the FIFO levels, the thresholds
// (already converted to 1..64) and the remaining byte count.
// Draining is judged against the remaining count, not just the level.
module pace_events
    import pace_pkg::*;
#(
    parameter int LW = 5,
    parameter int CW = 16,
    localparam int TW = THR_W + 1,
    localparam int XW = ((CW > LW) ? CW : LW) + TW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [LW-1:0]  rx_level,
    input  logic [LW-1:0]  tx_level,
    input  logic [TW-1:0]  rx_thr,
    input  logic [TW-1:0]  tx_thr,
    input  logic [CW-1:0]  remaining,
    output logic [NEV-1:0] cond
);
    logic [XW-1:0] rl, tl, rt, tt, rem, unw;

    // Widen every operand to one compare width.
    always_comb begin
        rl  = XW'(rx_level);
        tl  = XW'(tx_level);
        rt  = XW'(rx_thr);
        tt  = XW'(tx_thr);
        rem = XW'(remaining);
        unw = (rem > tl) ? (rem - tl) : '0;
    end

    // Event conditions, one per status bit.
    always_comb begin
        cond            = '0;
        cond[EV_RX_RDY] = (rl >= rt);
        cond[EV_RX_DRN] = (rem == '0) && (rl != '0) && (rl < rt);
        cond[EV_TX_RDY] = (tl < tt) && (unw >= tt);
        cond[EV_TX_DRN] = (tl < tt) && (unw != '0) && (unw < tt);
    end

    assert_tx_ready_drain_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cond[EV_TX_RDY] && cond[EV_TX_DRN]));
    assert_rx_drain_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cond[EV_RX_DRN] |-> (remaining == '0) && !cond[EV_RX_RDY]);
endmodule

// File: rtl/pace_status.sv
// Sticky status bits with write-one-to-clear, enable set/clear and the
// interrupt OR. A clear wins for one cycle; a still-true event sets the
// bit again on the following cycle.
module pace_status #(
    parameter int NEV = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] cond,
    input  logic [NEV-1:0] clr_mask,
    input  logic [NEV-1:0] en_set,
    input  logic [NEV-1:0] en_clr,
    output logic [NEV-1:0] status,
    output logic [NEV-1:0] enable,
    output logic           irq
);
    for (genvar i = 0; i < NEV; i++) begin : g_bit
        logic st_q, en_q;

        // Status latch: clear has priority, else the event sets it.
        always_ff @(posedge clk) begin
            if (!rst_n)           st_q <= 1'b0;
            else if (clr_mask[i]) st_q <= 1'b0;
            else if (cond[i])     st_q <= 1'b1;
        end

        // Enable latch: clear register has priority over set register.
        always_ff @(posedge clk) begin
            if (!rst_n)         en_q <= 1'b0;
            else if (en_clr[i]) en_q <= 1'b0;
            else if (en_set[i]) en_q <= 1'b1;
        end

        assign status[i] = st_q;
        assign enable[i] = en_q;

        assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            clr_mask[i] |=> !status[i]);
        // Covers R3 R4 R5 R6: a true event always lands in its bit.
        assert_event_latches_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cond[i] && !clr_mask[i]) |=> status[i]);
        assert_enable_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (en_set[i] && !en_clr[i]) |=> enable[i]);
        assert_enable_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
            en_clr[i] |=> !enable[i]);
    end

    assign irq = |(status & enable);
endmodule

// File: rtl/fifo_pace_irq.sv
// Top of the FIFO pacing block: register decode, thresholds, remaining
// byte counter, both FIFOs, event logic and status bank.
// Assumes CW <= 16 and that one transfer moves bytes in one direction.
module fifo_pace_irq
    import pace_pkg::*;
#(
    parameter int DW         = 8,
    parameter int DEPTH_CODE = 1,
    parameter int CW         = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          eng_rx_push,
    input  logic [DW-1:0] eng_rx_data,
    output logic          eng_rx_room,
    input  logic          eng_tx_pop,
    output logic [DW-1:0] eng_tx_data,
    output logic          eng_tx_avail,
    output logic          irq
);
    localparam int DEPTH = 8 << DEPTH_CODE;
    localparam int LW    = $clog2(DEPTH) + 1;
    localparam int TW    = THR_W + 1;

    pace_addr_e    addr;
    logic          wr_cfg, wr_cnt, wr_stat, wr_enset, wr_enclr, wr_data, rd_data;
    logic [THR_W-1:0] tx_thr_f, rx_thr_f;
    logic          tx_clr, rx_clr;
    logic [CW-1:0] remaining;
    logic          moved;
    logic [LW-1:0] tx_level, rx_level;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [DW-1:0] rx_head;
    logic [NEV-1:0] cond, status, enable;

    assign addr     = pace_addr_e'(reg_addr);
    assign wr_cfg   = reg_wr && (addr == A_CFG);
    assign wr_cnt   = reg_wr && (addr == A_COUNT);
    assign wr_stat  = reg_wr && (addr == A_STAT);
    assign wr_enset = reg_wr && (addr == A_ENSET);
    assign wr_enclr = reg_wr && (addr == A_ENCLR);
    assign wr_data  = reg_wr && (addr == A_DATA);
    assign rd_data  = reg_rd && (addr == A_DATA);
    assign tx_clr   = wr_cfg && reg_wdata[CFG_TXCLR];
    assign rx_clr   = wr_cfg && reg_wdata[CFG_RXCLR];

    // Threshold fields, stored as threshold minus one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr_f <= '0;
            rx_thr_f <= '0;
        end else if (wr_cfg) begin
            tx_thr_f <= reg_wdata[TX_THR_LSB +: THR_W];
            rx_thr_f <= reg_wdata[RX_THR_LSB +: THR_W];
        end
    end

    assign moved = (eng_rx_push && !rx_full) || (eng_tx_pop && !tx_empty);

    // Remaining byte counter: nonzero load, else count engine moves to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remaining <= '0;
        else if (wr_cnt && (reg_wdata[CW-1:0] != '0))
            remaining <= reg_wdata[CW-1:0];
        else if (moved && (remaining != '0))
            remaining <= remaining - 1'b1;
    end

    pace_fifo #(.DW(DW), .DEPTH(DEPTH)) i_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(wr_data), .push_data(reg_wdata[DW-1:0]),
        .pop(eng_tx_pop), .head(eng_tx_data),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    pace_fifo #(.DW(DW), .DEPTH(DEPTH)) i_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(rd_data), .head(rx_head),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    pace_events #(.LW(LW), .CW(CW)) i_events (
        .clk(clk), .rst_n(rst_n),
        .rx_level(rx_level), .tx_level(tx_level),
        .rx_thr(TW'(rx_thr_f) + 1'b1), .tx_thr(TW'(tx_thr_f) + 1'b1),
        .remaining(remaining), .cond(cond)
    );

    pace_status #(.NEV(NEV)) i_status (
        .clk(clk), .rst_n(rst_n), .cond(cond),
        .clr_mask(wr_stat  ? reg_wdata[NEV-1:0] : '0),
        .en_set  (wr_enset ? reg_wdata[NEV-1:0] : '0),
        .en_clr  (wr_enclr ? reg_wdata[NEV-1:0] : '0),
        .status(status), .enable(enable), .irq(irq)
    );

    assign eng_rx_room  = !rx_full;
    assign eng_tx_avail = !tx_empty;

    // Read data multiplexer for the register port.
    always_comb begin
        unique case (addr)
            A_CFG:   reg_rdata = {2'b00, rx_thr_f, 2'b00, tx_thr_f};
            A_COUNT: reg_rdata = RW'(remaining);
            A_STAT:  reg_rdata = RW'(status & enable);
            A_RAW:   reg_rdata = RW'(status);
            A_ENSET: reg_rdata = RW'(enable);
            A_ENCLR: reg_rdata = RW'(enable);
            A_DATA:  reg_rdata = rx_empty ? '0 : RW'(rx_head);
            A_INFO:  reg_rdata = {13'b0, 3'(DEPTH_CODE)};
            default: reg_rdata = '0;
        endcase
    end

    assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (moved && !wr_cnt && (remaining != '0)) |=> (remaining == $past(remaining) - 1'b1));
    assert_zero_len_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && (reg_wdata[CW-1:0] == '0) && !moved) |=> $stable(remaining));
    assert_count_floor_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining == '0 && !wr_cnt) |=> (remaining == '0));
endmodule

// File: tb/test_fifo_pace_irq.sv
module test_fifo_pace_irq;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH_CODE = 1;
    localparam int DEPTH      = 8 << DEPTH_CODE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_rx_room;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_avail;
    logic        irq;

    int n_checks = 0;
    int n_err    = 0;

    // bench model
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    int rem = 0, rt = 1, tt = 1;
    logic [3:0] en_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_pace_irq #(.DW(8), .DEPTH_CODE(DEPTH_CODE), .CW(16)) i_fifo_pace_irq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_room(eng_rx_room),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] exp_cond(int rl, int tl, int rthr, int tthr, int r);
        logic [3:0] c;
        int unw;
        unw  = (r > tl) ? r - tl : 0;
        c[0] = (rl >= rthr);
        c[1] = (r == 0) && (rl > 0) && (rl < rthr);
        c[2] = (tl < tthr) && (unw >= tthr);
        c[3] = (tl < tthr) && (unw > 0) && (unw < tthr);
        return c;
    endfunction

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic eng_push(input logic [7:0] b);
        eng_rx_push = 1'b1; eng_rx_data = b;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic eng_pop(output logic [7:0] d);
        eng_tx_pop = 1'b1;
        #1 d = eng_tx_data;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    // Clear all status, let one cycle pass, then read raw status.
    task automatic fresh_raw(output logic [15:0] v);
        wr(3'd2, 16'h000F);
        @(negedge clk);
        rd(3'd3, v);
    endtask

    task automatic set_cfg(input int txf, input int rxf, input bit tclr, input bit rclr);
        wr(3'd0, 16'((rxf << 8) | txf | (int'(tclr) << 6) | (int'(rclr) << 14)));
        tt = txf + 1; rt = rxf + 1;
        if (tclr) txq.delete();
        if (rclr) rxq.delete();
    endtask

    task automatic model_rx_push(input logic [7:0] b);
        if (rxq.size() < DEPTH) begin
            rxq.push_back(b);
            if (rem > 0) rem--;
        end
        eng_push(b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  d;
        int n;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd3, v); check("R1 raw status", v, 0);
        rd(3'd4, v); check("R1 enables", v, 0);
        rd(3'd1, v); check("R1 remaining", v, 0);
        rd(3'd0, v); check("R1 config", v, 0);
        check("R1 irq", irq, 0);
        check("R1 tx avail", eng_tx_avail, 0);
        check("R1 rx room", eng_rx_room, 1);

        // R10 depth code
        rd(3'd7, v); check("R10 depth code", v, DEPTH_CODE);

        // R2 field readback; R9 clear bits read 0
        wr(3'd0, 16'hFFFF);
        rd(3'd0, v); check("R2 R9 config readback", v, 16'h3F3F);
        set_cfg(0, 0, 1, 1);

        // R11 zero length ignored
        wr(3'd1, 16'd5); wr(3'd1, 16'd0);
        rd(3'd1, v); check("R11 zero write ignored", v, 5);

        // R10 R12 depth and order
        wr(3'd1, 16'd40);
        for (int i = 0; i < DEPTH + 1; i++) wr(3'd6, 16'(i + 8'h30));
        n = 0;
        while (eng_tx_avail && n < DEPTH + 4) begin
            eng_pop(d);
            check("R12 tx order", d, 8'(n + 8'h30));
            n++;
        end
        check("R10 tx holds depth", n, DEPTH);
        rd(3'd1, v); check("R11 count after pops", v, 40 - DEPTH);

        // R3 R4 directed: rx threshold 2, count 3
        set_cfg(0, 1, 1, 1); rem = 0;
        wr(3'd1, 16'd3); rem = 3;
        model_rx_push(8'hA1);
        fresh_raw(v); check("R4 no drain while bytes remain", v[1:0], 2'b00);
        model_rx_push(8'hA2);
        fresh_raw(v); check("R3 rx ready at threshold", v[1:0], 2'b01);
        rd(3'd6, v); check("R12 rx data 1", v, 8'hA1); void'(rxq.pop_front());
        rd(3'd6, v); check("R12 rx data 2", v, 8'hA2); void'(rxq.pop_front());
        model_rx_push(8'hA3);
        fresh_raw(v); check("R4 rx drain on last byte", v[1:0], 2'b10);
        rd(3'd6, v); void'(rxq.pop_front());
        rd(3'd6, v); check("R12 empty read zero", v, 0);

        // R5 R6 directed: tx threshold 4, count 10
        set_cfg(3, 0, 1, 1);
        wr(3'd1, 16'd10); rem = 10;
        fresh_raw(v); check("R5 tx ready empty fifo", v[3:2], 2'b01);
        for (int i = 0; i < 7; i++) begin wr(3'd6, 16'(i)); txq.push_back(8'(i)); end
        fresh_raw(v); check("R5 no tx event above threshold", v[3:2], 2'b00);
        for (int i = 0; i < 4; i++) begin eng_pop(d); void'(txq.pop_front()); rem--; end
        fresh_raw(v); check("R6 tx drain short remainder", v[3:2], 2'b10);

        // R9 clears
        set_cfg(0, 0, 1, 0);
        check("R9 tx cleared", eng_tx_avail, 0);
        eng_push(8'h11); eng_push(8'h22); rxq.push_back(8'h11); rxq.push_back(8'h22);
        set_cfg(0, 0, 0, 1);
        rd(3'd6, v); check("R9 rx cleared", v, 0);

        // R7 R8 sticky bit, zero write, enables and irq
        set_cfg(0, 0, 1, 1);
        wr(3'd1, 16'd1); rem = 1;
        eng_push(8'h55); rem = 0;
        @(negedge clk);
        rd(3'd6, v); check("R12 rx single", v, 8'h55);
        rd(3'd3, v); check("R7 sticky after condition gone", v[0], 1);
        wr(3'd2, 16'h0000);
        rd(3'd3, v); check("R7 zero write no effect", v[0], 1);
        wr(3'd4, 16'h000F); wr(3'd5, 16'h000E); en_m = 4'h1;
        rd(3'd4, v); check("R8 enable readback", v, 1);
        rd(3'd2, v); check("R8 masked status", v, 1);
        #1 check("R8 irq high", irq, 1);
        wr(3'd2, 16'h0001);
        @(negedge clk);
        rd(3'd3, v); check("R7 cleared stays clear", v[0], 0);
        check("R8 irq low", irq, 0);

        // Random walk with per-step condition checks
        set_cfg(0, 0, 1, 1); rem = 0;
        for (int step = 0; step < 400; step++) begin
            int op;
            logic [3:0] c;
            op = $urandom_range(0, 9);
            if (op <= 1) begin
                d = 8'($urandom());
                if (txq.size() < DEPTH) txq.push_back(d);
                wr(3'd6, 16'(d));
            end else if (op <= 3) begin
                eng_pop(d);
                if (txq.size() > 0) begin
                    check("R12 random tx order", d, txq[0]);
                    void'(txq.pop_front());
                    if (rem > 0) rem--;
                end
            end else if (op <= 5) begin
                model_rx_push(8'($urandom()));
            end else if (op <= 7) begin
                rd(3'd6, v);
                check("R12 random rx data", v, (rxq.size() > 0) ? 16'(rxq[0]) : 16'h0);
                if (rxq.size() > 0) void'(rxq.pop_front());
            end else if (op == 8) begin
                n = $urandom_range(0, 30);
                wr(3'd1, 16'(n));
                if (n != 0) rem = n;
            end else begin
                set_cfg($urandom_range(0, 5), $urandom_range(0, 5),
                        ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
                en_m = 4'($urandom());
                wr(3'd5, 16'h000F); wr(3'd4, 16'(en_m));
            end
            c = exp_cond(rxq.size(), txq.size(), rt, tt, rem);
            fresh_raw(v);
            check("R3 R4 R5 R6 R7 raw status", v, 16'(c));
            check("R8 irq", irq, |(c & en_m));
            rd(3'd1, v);
            check("R11 remaining", v, 16'(rem));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule